// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This engine drains a ring of transmit buffer descriptors kept in system memory. Each descriptor spans 8 bytes. It holds a big-endian control half-word, a big-endian byte count and a big-endian 32-bit buffer pointer. The engine reads each descriptor in turn and pulls its buffer one byte at a time through a 32-bit word read port. It gathers the bytes of one or more buffers into an internal frame store. When it meets the buffer that closes a frame, it plays the whole frame out on a byte stream with valid/ready/last handshaking.

Software programs the ring origin and sets the enable flag in the control register. It then writes the demand register to start a walk. The walk continues until it reaches a descriptor that is not owned by the engine. After each descriptor is used, the engine writes it back with the ownership bit cleared and pulses a per-buffer event. A closing buffer also pulses a per-frame event. A hard frame limit clips oversized frames and signals a babble event. The current descriptor address is always visible on an output.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset, desc_ptr is 0, tx_valid and tx_last are low, mem_req is low and no event output is high.
- R2: A write to the demand offset (0x014) starts a walk only if bit 1 of the control register (offset 0x024) was already set. Otherwise the write causes no memory access.
- R3: A write to the ring-origin offset (0x184) stores the written value with bits 1:0 forced to zero. When no walk is running, the same write also loads that value into desc_ptr.
- R4: A descriptor's first word is read at desc_ptr, with flags in bits 31:16 and byte count in bits 15:0. Its second word, at desc_ptr+4, is the buffer byte address. If flag bit 15 (ready) is clear, the walk ends and desc_ptr stays at that descriptor.
- R5: A buffer byte at address a is taken from the word at a with bits 1:0 cleared. Offset 0 sits in bits 31:24 and offset 3 in bits 7:0. Bytes leave the stream in ascending address order.
- R6: Buffers are concatenated into one frame until a descriptor with flag bit 11 (last) has been consumed. Only then is the frame streamed, with tx_last high on its final byte only. A frame of zero bytes produces no stream beats.
- R7: Each consumed descriptor is written back at its own address: the first word keeps its byte count and all flags except bit 15, which is cleared.
- R8: After write-back, desc_ptr moves to the ring origin if flag bit 13 (wrap) is set, and to desc_ptr+8 otherwise.
- R9: ev_buf pulses for one cycle, in the same cycle as each descriptor write-back. ev_frame pulses with it when the descriptor has the last flag.
- R10: A frame holds at most 2032 bytes. A buffer that would exceed this contributes only the bytes that still fit, and ev_babble pulses with that descriptor's ev_buf.
- R11: While tx_valid is high and tx_ready low, tx_data and tx_last hold steady. No memory request is issued while a frame is being streamed.
- R12: A demand write that arrives while a walk is running has no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request; read data returns next cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| tx_data | output | 8 | Frame stream byte |
| tx_valid | output | 1 | Frame stream byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| ev_buf | output | 1 | Pulse: one descriptor consumed |
| ev_frame | output | 1 | Pulse: closing descriptor consumed |
| ev_babble | output | 1 | Pulse: frame clipped at the size limit |
| desc_ptr | output | 32 | Address of the current descriptor |

## Verification
The bench builds the block with its default parameters: a 2032-byte frame limit, big-endian byte lanes and the standard register offsets. Because the limit stays at its full size, a two-descriptor frame of 2000 plus 100 bytes reaches the clip point in a few thousand cycles, so the truncation and babble path is exercised at the real boundary. Buffer start offsets cover all four byte lanes. Zero-length buffers and a throttled tx_ready show that the gather and the stream stall behave without parameter changes.

// File: rtl/trw_pkg.sv
package trw_pkg;
   localparam int unsigned DESC_STRIDE = 8;
   localparam int unsigned FL_READY    = 15;
   localparam int unsigned FL_WRAP     = 13;
   localparam int unsigned FL_LAST     = 11;
   localparam int unsigned MEM_DW      = 32;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HEAD,
      ST_CHECK,
      ST_ADDR,
      ST_BREQ,
      ST_BDAT,
      ST_WBACK,
      ST_SEND
   } walk_state_t;

   typedef struct packed {
      logic [15:0] flags;
      logic [15:0] len;
   } desc_head_t;
endpackage

// File: rtl/trw_regs.sv
module trw_regs #(
   parameter int unsigned RAW        = 10,
   parameter int unsigned DW         = 32,
   parameter logic [RAW-1:0] OFS_CTRL   = 10'h024,
   parameter logic [RAW-1:0] OFS_DEMAND = 10'h014,
   parameter logic [RAW-1:0] OFS_RING   = 10'h184,
   parameter int unsigned EN_BIT     = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_we,
   input  logic [RAW-1:0] reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic           go,
   output logic           ring_wr,
   output logic [DW-1:0]  ring_val,
   output logic [DW-1:0]  ring_base
);
   localparam logic [DW-1:0] ALIGN_MASK = ~DW'(3);

   generate
      if (EN_BIT >= DW) begin : g_bad_en
         $error("EN_BIT must lie inside the data word");
      end
      if (DW < 3) begin : g_bad_dw
         $error("DW too narrow for an aligned pointer");
      end
   endgenerate

   logic en_q;

   assign go       = reg_we && (reg_addr == OFS_DEMAND) && en_q;
   assign ring_wr  = reg_we && (reg_addr == OFS_RING);
   assign ring_val = reg_wdata & ALIGN_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         ring_base <= '0;
      end else begin
         if (reg_we && (reg_addr == OFS_CTRL)) en_q <= reg_wdata[EN_BIT];
         if (ring_wr) ring_base <= ring_val;
      end
   end
endmodule

// File: rtl/trw_fbuf.sv
module trw_fbuf #(
   parameter int unsigned CAP = 2032,
   parameter int unsigned CW  = $clog2(CAP + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_byte,
   input  logic          clr,
   input  logic [CW-1:0] rd_idx,
   output logic [7:0]    rd_byte,
   output logic [CW-1:0] count
);
   localparam int unsigned IW = (CAP > 1) ? $clog2(CAP) : 1;
   localparam logic [CW-1:0] CAP_C = CW'(CAP);

   generate
      if (CAP < 1 || CAP > 65535) begin : g_bad_cap
         $error("CAP must be between 1 and 65535");
      end
   endgenerate

   logic [7:0] store [CAP];
   logic       room_ok;

   assign room_ok = count < CAP_C;
   assign rd_byte = store[IW'(rd_idx)];

   always_ff @(posedge clk) begin
      if (wr_en && room_ok) store[IW'(count)] <= wr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (clr)              count <= '0;
      else if (wr_en && room_ok) count <= count + CW'(1);
   end
endmodule

// File: rtl/trw_walker.sv
module trw_walker
   import trw_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned CAP      = 2032,
   parameter int unsigned CW       = $clog2(CAP + 1),
   parameter bit          BE_LANES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              ring_wr,
   input  logic [AW-1:0]     ring_val,
   input  logic [AW-1:0]     ring_base,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [MEM_DW-1:0] mem_wdata,
   input  logic [MEM_DW-1:0] mem_rdata,
   output logic              fb_wr,
   output logic [7:0]        fb_byte,
   output logic              fb_clr,
   output logic [CW-1:0]     fb_rd_idx,
   input  logic [7:0]        fb_rd_byte,
   input  logic [CW-1:0]     fb_count,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              ev_buf,
   output logic              ev_frame,
   output logic              ev_babble,
   output logic [AW-1:0]     desc_ptr
);
   localparam logic [CW-1:0] CAP_C    = CW'(CAP);
   localparam logic [AW-1:0] STRIDE   = AW'(DESC_STRIDE);
   localparam logic [AW-1:0] WORD_OFS = AW'(4);
   localparam logic [15:0]   RDY_MASK = 16'(1 << FL_READY);

   generate
      if (CW > 16) begin : g_bad_cw
         $error("frame limit must fit the 16-bit byte count");
      end
      if (AW < 3) begin : g_bad_aw
         $error("AW too narrow");
      end
   endgenerate

   walk_state_t st;
   desc_head_t  head;
   logic [AW-1:0] ptr, baddr;
   logic [15:0]   take, idx;
   logic [1:0]    lane;
   logic          bab_q;
   logic [CW-1:0] rd_idx;

   logic [CW-1:0] room;
   logic [15:0]   room16, grant;
   logic          over;
   logic [AW-1:0] byte_addr;
   logic [7:0]    lane_byte;
   logic          last_beat;

   assign room      = CAP_C - fb_count;
   assign room16    = 16'(room);
   assign over      = head.len > room16;
   assign grant     = over ? room16 : head.len;
   assign byte_addr = baddr + AW'(idx);
   assign last_beat = (rd_idx == fb_count - CW'(1));

   generate
      if (BE_LANES) begin : g_lane_be
         always_comb lane_byte = mem_rdata[{~lane, 3'b000} +: 8];
      end else begin : g_lane_le
         always_comb lane_byte = mem_rdata[{lane, 3'b000} +: 8];
      end
   endgenerate

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = ptr;
      mem_wdata = {head.flags & ~RDY_MASK, head.len};
      unique case (st)
         ST_HEAD:  mem_req = 1'b1;
         ST_CHECK: begin
            mem_req  = mem_rdata[16 + FL_READY];
            mem_addr = ptr + WORD_OFS;
         end
         ST_BREQ: begin
            mem_req  = 1'b1;
            mem_addr = {byte_addr[AW-1:2], 2'b00};
         end
         ST_WBACK: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         default: ;
      endcase
   end

   assign tx_valid  = (st == ST_SEND);
   assign tx_data   = fb_rd_byte;
   assign tx_last   = tx_valid && last_beat;
   assign ev_buf    = (st == ST_WBACK);
   assign ev_frame  = ev_buf && head.flags[FL_LAST];
   assign ev_babble = ev_buf && bab_q;
   assign fb_wr     = (st == ST_BDAT);
   assign fb_byte   = lane_byte;
   assign fb_clr    = tx_last && tx_ready;
   assign fb_rd_idx = rd_idx;
   assign desc_ptr  = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         head   <= '0;
         ptr    <= '0;
         baddr  <= '0;
         take   <= '0;
         idx    <= '0;
         lane   <= '0;
         bab_q  <= 1'b0;
         rd_idx <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (ring_wr) ptr <= ring_val;
               if (go) st <= ST_HEAD;
            end
            ST_HEAD: st <= ST_CHECK;
            ST_CHECK: begin
               if (mem_rdata[16 + FL_READY]) begin
                  head <= mem_rdata;
                  st   <= ST_ADDR;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_ADDR: begin
               baddr <= mem_rdata;
               idx   <= '0;
               take  <= grant;
               bab_q <= over;
               st    <= (grant == 16'd0) ? ST_WBACK : ST_BREQ;
            end
            ST_BREQ: begin
               lane <= byte_addr[1:0];
               st   <= ST_BDAT;
            end
            ST_BDAT: begin
               idx <= idx + 16'd1;
               st  <= (idx + 16'd1 == take) ? ST_WBACK : ST_BREQ;
            end
            ST_WBACK: begin
               ptr <= head.flags[FL_WRAP] ? ring_base : ptr + STRIDE;
               if (head.flags[FL_LAST] && fb_count != '0) begin
                  rd_idx <= '0;
                  st     <= ST_SEND;
               end else begin
                  st <= ST_HEAD;
               end
            end
            ST_SEND: begin
               if (tx_ready) begin
                  if (last_beat) st <= ST_HEAD;
                  else           rd_idx <= rd_idx + CW'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
   parameter int unsigned CAP        = 2032,
   parameter int unsigned RAW        = 10,
   parameter logic [9:0]  OFS_CTRL   = 10'h024,
   parameter logic [9:0]  OFS_DEMAND = 10'h014,
   parameter logic [9:0]  OFS_RING   = 10'h184,
   parameter int unsigned EN_BIT     = 1,
   parameter bit          BE_LANES   = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_we,
   input  logic [RAW-1:0] reg_addr,
   input  logic [31:0]    reg_wdata,
   output logic           mem_req,
   output logic           mem_we,
   output logic [31:0]    mem_addr,
   output logic [31:0]    mem_wdata,
   input  logic [31:0]    mem_rdata,
   output logic [7:0]     tx_data,
   output logic           tx_valid,
   output logic           tx_last,
   input  logic           tx_ready,
   output logic           ev_buf,
   output logic           ev_frame,
   output logic           ev_babble,
   output logic [31:0]    desc_ptr
);
   localparam int unsigned CW = $clog2(CAP + 1);
   localparam int unsigned AW = 32;

   generate
      if (RAW != 10) begin : g_bad_raw
         $error("register offsets are 10 bits wide");
      end
   endgenerate

   logic          go, ring_wr;
   logic [AW-1:0] ring_val, ring_base;
   logic          fb_wr, fb_clr;
   logic [7:0]    fb_byte, fb_rd_byte;
   logic [CW-1:0] fb_rd_idx, fb_count;

   trw_regs #(
      .RAW(RAW), .DW(AW), .OFS_CTRL(OFS_CTRL), .OFS_DEMAND(OFS_DEMAND),
      .OFS_RING(OFS_RING), .EN_BIT(EN_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .go(go), .ring_wr(ring_wr),
      .ring_val(ring_val), .ring_base(ring_base)
   );

   trw_fbuf #(.CAP(CAP), .CW(CW)) u_fbuf (
      .clk(clk), .rst_n(rst_n), .wr_en(fb_wr), .wr_byte(fb_byte),
      .clr(fb_clr), .rd_idx(fb_rd_idx), .rd_byte(fb_rd_byte),
      .count(fb_count)
   );

   trw_walker #(.AW(AW), .CAP(CAP), .CW(CW), .BE_LANES(BE_LANES)) u_walk (
      .clk(clk), .rst_n(rst_n), .go(go), .ring_wr(ring_wr),
      .ring_val(ring_val), .ring_base(ring_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .fb_wr(fb_wr), .fb_byte(fb_byte), .fb_clr(fb_clr),
      .fb_rd_idx(fb_rd_idx), .fb_rd_byte(fb_rd_byte), .fb_count(fb_count),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
      .tx_ready(tx_ready), .ev_buf(ev_buf), .ev_frame(ev_frame),
      .ev_babble(ev_babble), .desc_ptr(desc_ptr)
   );
endmodule

// File: rtl/trw_checker.sv
module trw_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [31:0] mem_wdata,
   input logic [7:0]  tx_data,
   input logic        tx_valid,
   input logic        tx_last,
   input logic        tx_ready,
   input logic        ev_buf,
   input logic        ev_frame,
   input logic        ev_babble,
   input logic [31:0] desc_ptr
);
   a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

   a_r11_no_fetch_in_send: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !mem_req);

   a_r6_last_inside_beat: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   a_r9_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame |-> ev_buf);

   a_r10_babble_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
      ev_babble |-> ev_buf);

   a_r9_buf_at_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      ev_buf |-> mem_req && mem_we && mem_addr == desc_ptr);

   a_r7_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !mem_wdata[31]);

   a_r3_aligned_access: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00 && desc_ptr[1:0] == 2'b00);
endmodule

bind tx_ring_walker trw_checker u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_data(tx_data),
   .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
   .ev_buf(ev_buf), .ev_frame(ev_frame), .ev_babble(ev_babble),
   .desc_ptr(desc_ptr)
);

// File: tb/tb_tx_ring_walker.sv
`timescale 1ns/100ps
module tb_tx_ring_walker;
   localparam logic [9:0] A_CTRL = 10'h024;
   localparam logic [9:0] A_DMND = 10'h014;
   localparam logic [9:0] A_RING = 10'h184;
   localparam int NVEC = 4;
   // fields: len0[31:24] len1[23:16] lane offset[15:8] throttle[7:0]
   localparam logic [31:0] VEC [NVEC] = '{
      {8'd3, 8'd2, 8'd1, 8'd0},
      {8'd1, 8'd4, 8'd3, 8'd1},
      {8'd6, 8'd0, 8'd0, 8'd1},
      {8'd0, 8'd5, 8'd2, 8'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [9:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, desc_ptr;
   logic [31:0] mem_rdata = '0;
   logic [7:0] tx_data;
   logic tx_valid, tx_last, ev_buf, ev_frame, ev_babble;
   logic tx_ready = 1'b1;
   logic throttle = 1'b0;

   int n_tests = 0, n_fail = 0;
   int nb, nlast, lastpos, nbuf, nframe, nbab, nrd;
   logic [7:0] capb [0:2199];
   logic [31:0] mem [0:1023];

   always #2.5 clk = ~clk;

   tx_ring_walker dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
      .tx_ready(tx_ready), .ev_buf(ev_buf), .ev_frame(ev_frame),
      .ev_babble(ev_babble), .desc_ptr(desc_ptr)
   );

   function automatic logic [7:0] pat(int a);
      return 8'(((a & 32'hFFF) * 13) + 5);
   endfunction

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
         mem_rdata <= mem[mem_addr[11:2]];
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid && tx_ready) begin
            if (nb < 2200) capb[nb] = tx_data;
            if (tx_last) begin nlast++; lastpos = nb; end
            nb++;
         end
         if (ev_buf) nbuf++;
         if (ev_frame) nframe++;
         if (ev_babble) nbab++;
         if (mem_req && !mem_we) nrd++;
      end
   end

   initial begin
      forever begin
         @(posedge clk); #1;
         tx_ready = throttle ? ~tx_ready : 1'b1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      nb = 0; nlast = 0; lastpos = -1; nbuf = 0; nframe = 0; nbab = 0; nrd = 0;
   endtask

   task automatic reg_write(input logic [9:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      int guard = 0;
      while (quiet < 8 && guard < 20000) begin
         @(negedge clk);
         if (!mem_req && !tx_valid) quiet++; else quiet = 0;
         guard++;
      end
      if (guard >= 20000) chk(1'b0, "walk timeout", guard, 0);
   endtask

   task automatic put_desc(input int at, input logic [15:0] fl, input logic [15:0] ln, input logic [31:0] ba);
      mem[at >> 2]       <= {fl, ln};
      mem[(at >> 2) + 1] <= ba;
   endtask

   task automatic check_bytes(input string req, input int a0, input int l0, input int a1);
      int bad = -1;
      for (int k = 0; k < nb && k < 2200; k++) begin
         logic [7:0] e;
         e = (k < l0) ? pat(a0 + k) : pat(a1 + k - l0);
         if (bad < 0 && capb[k] != e) bad = k;
      end
      if (bad >= 0) chk(1'b0, req, capb[bad], (bad < l0) ? pat(a0 + bad) : pat(a1 + bad - l0));
      else chk(1'b1, req, 0, 0);
   endtask

   initial begin
      #(200000 * 5);
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int w = 0; w < 1024; w++)
         mem[w] <= {pat(4*w), pat(4*w+1), pat(4*w+2), pat(4*w+3)};
      clear_mon();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(desc_ptr == 32'h0, "R1 desc_ptr", desc_ptr, 0);
      chk(!tx_valid && !tx_last, "R1 stream idle", tx_valid, 0);
      chk(!mem_req, "R1 mem idle", mem_req, 0);
      chk(!ev_buf && !ev_frame && !ev_babble, "R1 events", {ev_buf, ev_frame, ev_babble}, 0);

      // R3 ring origin alignment and pointer reload
      reg_write(A_RING, 32'h0000_01C3);
      @(negedge clk);
      chk(desc_ptr == 32'h1C0, "R3 ring reload", desc_ptr, 32'h1C0);

      // R2 demand without enable
      put_desc(32'h1C0, 16'h8800, 16'd2, 32'h900);
      clear_mon();
      reg_write(A_DMND, 32'h1);
      repeat (10) @(negedge clk);
      chk(nrd == 0, "R2 disabled demand", nrd, 0);
      reg_write(A_CTRL, 32'h2);
      put_desc(32'h1C0, 16'h0000, 16'd0, 32'h0);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         int base, a0, a1, l0, l1, off;
         l0 = int'(VEC[i][31:24]); l1 = int'(VEC[i][23:16]); off = int'(VEC[i][15:8]);
         base = 32'h100 + i * 32'h20;
         a0 = 32'h800 + i * 32'h40 + off;
         a1 = 32'hA00 + i * 32'h40 + (3 - off);
         put_desc(base, 16'h8000, 16'(l0), a0);
         put_desc(base + 8, 16'h8800, 16'(l1), a1);
         put_desc(base + 16, 16'h0000, 16'd0, 32'h0);
         throttle = VEC[i][0];
         clear_mon();
         reg_write(A_RING, base);
         reg_write(A_DMND, 32'h0);
         wait_idle();
         throttle = 1'b0;
         chk(nb == l0 + l1, "R6 frame length", nb, l0 + l1);
         check_bytes("R5 byte order", a0, l0, a1);
         chk(nlast == 1 && lastpos == nb - 1, "R6 single last", lastpos, nb - 1);
         chk(nbuf == 2 && nframe == 1, "R9 event counts", {nbuf[7:0], nframe[7:0]}, 16'h0201);
         chk(nbab == 0, "R10 no babble", nbab, 0);
         chk(mem[base >> 2] == {16'h0000, 16'(l0)}, "R7 writeback first", mem[base >> 2], l0);
         chk(mem[(base + 8) >> 2] == {16'h0800, 16'(l1)}, "R7 writeback last", mem[(base + 8) >> 2], {16'h0800, 16'(l1)});
         chk(desc_ptr == base + 16, "R4 stop at not ready", desc_ptr, base + 16);
      end

      // R4 immediate stop
      put_desc(32'h260, 16'h0000, 16'd4, 32'h900);
      clear_mon();
      reg_write(A_RING, 32'h260);
      reg_write(A_DMND, 32'h0);
      wait_idle();
      chk(nrd == 1 && nbuf == 0, "R4 single header read", nrd, 1);
      chk(desc_ptr == 32'h260, "R4 pointer kept", desc_ptr, 32'h260);

      // R8 wrap to ring origin
      put_desc(32'h240, 16'hA800, 16'd2, 32'h900);
      clear_mon();
      reg_write(A_RING, 32'h240);
      reg_write(A_DMND, 32'h0);
      wait_idle();
      chk(desc_ptr == 32'h240, "R8 wrap pointer", desc_ptr, 32'h240);
      chk(nbuf == 1 && nb == 2, "R8 wrap single buffer", nbuf, 1);
      chk(mem[32'h240 >> 2] == 32'h2800_0002, "R7 wrap writeback", mem[32'h240 >> 2], 32'h2800_0002);

      // R6 zero-byte frame
      put_desc(32'h280, 16'h8800, 16'd0, 32'h900);
      put_desc(32'h288, 16'h0000, 16'd0, 32'h0);
      clear_mon();
      reg_write(A_RING, 32'h280);
      reg_write(A_DMND, 32'h0);
      wait_idle();
      chk(nb == 0 && nframe == 1, "R6 empty frame", nb, 0);
      chk(desc_ptr == 32'h288, "R8 advance by 8", desc_ptr, 32'h288);

      // R10 frame limit, R12 demand during walk
      put_desc(32'h200, 16'h8000, 16'd2000, 32'h400);
      put_desc(32'h208, 16'h8800, 16'd100, 32'hC00);
      put_desc(32'h210, 16'h0000, 16'd0, 32'h0);
      clear_mon();
      reg_write(A_RING, 32'h200);
      reg_write(A_DMND, 32'h0);
      repeat (20) @(posedge clk);
      reg_write(A_DMND, 32'h0);
      wait_idle();
      chk(nb == 2032, "R10 clipped length", nb, 2032);
      chk(nbab == 1, "R10 babble pulse", nbab, 1);
      check_bytes("R10 clipped content", 32'h400, 2000, 32'hC00);
      chk(nbuf == 2 && nframe == 1, "R12 demand ignored", nbuf, 2);
      chk(desc_ptr == 32'h210, "R12 final pointer", desc_ptr, 32'h210);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule